// File: doc/BRIEF.md
# Micro-Op Fusion and Unlamination Selector

This block sits between decode and issue/rename. Each accepted group carries up to four decoded instructions. The block decides, for every instruction that pairs a memory load with an ALU operation, whether the two micro-ops share one fused-domain slot. An instruction whose decoder fused the pair may still need the pair split into two slots before rename. The decision depends on the addressing-mode descriptor: an index register, an instruction-pointer-relative address, or an immediate operand. It also depends on whether the register destination is both read and written.

Each cycle the block packs the held group into at most four issue slots, in program order. An instruction's slots always leave together in the same cycle. When an instruction does not fit, it and every younger instruction wait for the next cycle. Each slot carries:

- a micro-op kind;
- the running tag of its parent instruction;
- an end-of-instruction flag, so that retirement can find instruction boundaries;
- a flag marking slots produced by unlamination;
- a flag marking that the slot's ALU work also resolves a fused conditional branch.

Every cycle the block also reports the fused-domain slot count and the unfused-domain micro-op count.

Top module: `mf_fuse_select`

## Requirements
- R1: After reset, `in_ready` is 1, no slot is valid, and both counts are 0.
- R2: A load+ALU instruction with no index and no instruction-pointer-relative address takes one slot of kind 2 (fused load+ALU). That slot has eoi=1 and split=0 and counts as 2 unfused micro-ops. This includes a compare of a base-only operand against an immediate.
- R3: A load+ALU instruction whose address is instruction-pointer-relative and which has an immediate is never fused. It takes two slots in order: kind 1 (load) with eoi=0, then kind 0 (ALU) with eoi=1. Both slots have split=0.
- R4: A load+ALU instruction with an index register and a destination that is not read-modify-write is unlaminated. It takes two slots, load then ALU, with split=1 on both.
- R5: A load+ALU instruction with an index register and a read-modify-write destination stays fused in one kind-2 slot.
- R6: An instruction without a load takes one kind-0 slot. A load without an ALU operation takes one kind-1 slot. Each counts as 1 unfused micro-op.
- R7: At most four slots are valid per cycle, and they fill from slot 0 upward. Instructions leave in lane order. Both slots of an instruction always leave in the same cycle. An instruction that does not fit, and all younger instructions, leave in the next cycle.
- R8: Instructions receive consecutive 4-bit tags modulo 16 across cycles and groups. All slots of one instruction carry its tag, and only its last slot has eoi=1.
- R9: An instruction's branch-fused input is reported on its kind-0 or kind-2 slot and never on a kind-1 slot. Macro-fusion and micro-fusion can therefore apply together.
- R10: A group presented with `in_ready`=1 is accepted at that clock edge, and its first slots appear in the following cycle. While `in_ready` is 0, the inputs are ignored. `in_ready` is 1 exactly when every remaining instruction of the held group leaves in the current cycle.
- R11: `out_fused_cnt` equals the number of valid slots. `out_unfused_cnt` equals the sum of the unfused micro-op counts of the instructions leaving that cycle.
- R12: Lanes whose `in_valid` bit is 0 produce no slots and consume no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Lane holds an instruction |
| in_has_load | input | 4 | Instruction reads a memory operand |
| in_has_alu | input | 4 | Instruction has an ALU operation |
| in_index | input | 4 | Address uses an index register |
| in_rip | input | 4 | Address is instruction-pointer-relative |
| in_imm | input | 4 | Instruction carries an immediate |
| in_rmw | input | 4 | Register destination is read-modify-write |
| in_brf | input | 4 | ALU operation also carries a fused conditional branch |
| in_ready | output | 1 | A new group is accepted at the next edge |
| out_slot_vld | output | 4 | Slot valid, one bit per slot |
| out_slot_kind | output | 8 | 2 bits per slot: 0 ALU, 1 load, 2 fused load+ALU |
| out_slot_tag | output | 16 | 4-bit parent instruction tag per slot |
| out_slot_eoi | output | 4 | Last slot of its instruction |
| out_slot_split | output | 4 | Slot comes from an unlaminated instruction |
| out_slot_br | output | 4 | Slot also resolves a fused branch |
| out_fused_cnt | output | 3 | Fused-domain slots this cycle |
| out_unfused_cnt | output | 4 | Unfused-domain micro-ops this cycle |

## Verification
A group sampled at an accepting edge shows its first slots during the next cycle. Each further cycle the group still needs comes one clock later, with no gap. The driver drives inputs on the falling edge. While driving a group, it predicts that group's per-cycle packing and per-slot records and pushes them in order onto two queues. A monitor samples the outputs on every falling edge. In each cycle with a valid slot, it pops one cycle record and one slot record per valid slot. Any output that appears too early, too late or while the queues are empty is therefore reported as a mismatch.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [1:0] {
    UK_ALU   = 2'd0,
    UK_LOAD  = 2'd1,
    UK_FUSED = 2'd2
  } uop_kind_e;

  // decoded instruction descriptor held per lane
  typedef struct packed {
    logic has_load;
    logic has_alu;
    logic index;
    logic rip;
    logic imm;
    logic rmw;
    logic brf;
  } insn_t;

  // per-instruction fusion decision
  typedef struct packed {
    logic      two;    // occupies two fused-domain slots
    logic      split;  // fused at decode, unlaminated before rename
    uop_kind_e kind;   // kind of the single slot when two == 0
    logic [1:0] uops;  // unfused-domain micro-op count
  } cls_t;

endpackage

// File: rtl/mf_classify.sv
module mf_classify
  import mf_pkg::*;
(
  input  logic has_load,
  input  logic has_alu,
  input  logic index,
  input  logic rip,
  input  logic imm,
  input  logic rmw,
  output cls_t cls
);

  always_comb begin
    cls.two   = 1'b0;
    cls.split = 1'b0;
    cls.kind  = UK_ALU;
    cls.uops  = 2'd1;
    if (has_load) begin
      if (!has_alu) begin
        cls.kind = UK_LOAD;
      end else begin
        cls.uops = 2'd2;
        cls.kind = UK_FUSED;
        if (rip && imm) begin
          // never fused at decode
          cls.two = 1'b1;
        end else if (index && !rmw) begin
          // fused at decode, undone before rename
          cls.two   = 1'b1;
          cls.split = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mf_packer.sv
module mf_packer #(
  parameter int G  = 4,
  parameter int W  = 4,
  parameter int CW = $clog2(W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [G-1:0]         pend,
  input  logic [G-1:0]         two,
  output logic [G-1:0]         issue,
  output logic [G-1:0][CW-1:0] off,
  output logic [CW-1:0]        fused_cnt
);

  always_comb begin
    int   cum;
    int   need;
    logic stop;
    cum   = 0;
    stop  = 1'b0;
    issue = '0;
    off   = '0;
    for (int i = 0; i < G; i++) begin
      off[i] = CW'(cum);
      need   = two[i] ? 2 : 1;
      if (pend[i] && !stop) begin
        if (cum + need <= W) begin
          issue[i] = 1'b1;
          cum      = cum + need;
        end else begin
          stop = 1'b1;
        end
      end
    end
    fused_cnt = CW'(cum);
  end

  // R7: a held group always makes progress
  a_r7_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> (|issue));

  a_r7_issue_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (issue & ~pend) == '0);

  generate
    for (genvar i = 1; i < G; i++) begin : g_order
      // R7: no lane leaves ahead of an older pending lane
      a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        issue[i] |-> (issue[i-1] || !pend[i-1]));
    end
  endgenerate

endmodule

// File: rtl/mf_emitter.sv
module mf_emitter
  import mf_pkg::*;
#(
  parameter int G     = 4,
  parameter int W     = 4,
  parameter int IDX_W = 4,
  parameter int CW    = $clog2(W + 1),
  parameter int UW    = $clog2(2 * W + 1),
  parameter int NW    = $clog2(G + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cls_t [G-1:0]            cls,
  input  logic [G-1:0]            brf,
  input  logic [G-1:0]            issue,
  input  logic [G-1:0][CW-1:0]    off,
  input  logic [IDX_W-1:0]        seq,
  output logic [W-1:0]            vld,
  output logic [W-1:0][1:0]       kind,
  output logic [W-1:0][IDX_W-1:0] tag,
  output logic [W-1:0]            eoi,
  output logic [W-1:0]            split,
  output logic [W-1:0]            br,
  output logic [UW-1:0]           unfused_cnt,
  output logic [NW-1:0]           n_issued
);

  logic [G-1:0][NW-1:0] rank;

  always_comb begin
    int cnt;
    int ufs;
    cnt = 0;
    ufs = 0;
    for (int i = 0; i < G; i++) begin
      rank[i] = NW'(cnt);
      if (issue[i]) begin
        cnt = cnt + 1;
        ufs = ufs + int'(cls[i].uops);
      end
    end
    n_issued    = NW'(cnt);
    unfused_cnt = UW'(ufs);
  end

  always_comb begin
    vld   = '0;
    kind  = '0;
    tag   = '0;
    eoi   = '0;
    split = '0;
    br    = '0;
    for (int s = 0; s < W; s++) begin
      for (int i = 0; i < G; i++) begin
        if (issue[i]) begin
          if (off[i] == CW'(s)) begin
            vld[s] = 1'b1;
            tag[s] = seq + IDX_W'(rank[i]);
            if (cls[i].two) begin
              kind[s]  = UK_LOAD;
              split[s] = cls[i].split;
            end else begin
              kind[s] = cls[i].kind;
              eoi[s]  = 1'b1;
              br[s]   = brf[i] && (cls[i].kind != UK_LOAD);
            end
          end else if (cls[i].two && (off[i] + CW'(1) == CW'(s))) begin
            vld[s]   = 1'b1;
            tag[s]   = seq + IDX_W'(rank[i]);
            kind[s]  = UK_ALU;
            eoi[s]   = 1'b1;
            split[s] = cls[i].split;
            br[s]    = brf[i];
          end
        end
      end
    end
  end

  generate
    for (genvar s = 0; s < W; s++) begin : g_slot
      // R9: a pure load slot never carries the branch
      a_r9_load_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[s] && kind[s] == UK_LOAD) |-> !br[s]);
      if (s < W - 1) begin : g_pair
        // R7: slots fill from slot 0 without holes
        a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
          vld[s+1] |-> vld[s]);
        // R8: an open instruction finishes in the next slot with its own tag
        a_r8_eoi_chain: assert property (@(posedge clk) disable iff (!rst_n)
          (vld[s] && !eoi[s]) |-> (vld[s+1] && eoi[s+1] && tag[s+1] == tag[s]));
      end else begin : g_last
        // R7: the last slot never leaves an instruction open
        a_r7_no_straddle: assert property (@(posedge clk) disable iff (!rst_n)
          vld[s] |-> eoi[s]);
      end
    end
  endgenerate

endmodule

// File: rtl/mf_fuse_select.sv
module mf_fuse_select
  import mf_pkg::*;
#(
  parameter int G     = 4,
  parameter int W     = 4,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [G-1:0]               in_valid,
  input  logic [G-1:0]               in_has_load,
  input  logic [G-1:0]               in_has_alu,
  input  logic [G-1:0]               in_index,
  input  logic [G-1:0]               in_rip,
  input  logic [G-1:0]               in_imm,
  input  logic [G-1:0]               in_rmw,
  input  logic [G-1:0]               in_brf,
  output logic                       in_ready,
  output logic [W-1:0]               out_slot_vld,
  output logic [2*W-1:0]             out_slot_kind,
  output logic [W*IDX_W-1:0]         out_slot_tag,
  output logic [W-1:0]               out_slot_eoi,
  output logic [W-1:0]               out_slot_split,
  output logic [W-1:0]               out_slot_br,
  output logic [$clog2(W+1)-1:0]     out_fused_cnt,
  output logic [$clog2(2*W+1)-1:0]   out_unfused_cnt
);

  localparam int CW = $clog2(W + 1);
  localparam int UW = $clog2(2 * W + 1);
  localparam int NW = $clog2(G + 1);

  insn_t [G-1:0]          in_insn;
  insn_t [G-1:0]          grp_q, grp_n;
  logic  [G-1:0]          pend_q, pend_n, pend_after;
  logic  [IDX_W-1:0]      seq_q, seq_n;
  cls_t  [G-1:0]          cls;
  logic  [G-1:0]          two, brf, issue;
  logic  [G-1:0][CW-1:0]  off;
  logic  [NW-1:0]         n_issued;
  logic  [W-1:0][1:0]       kind_a;
  logic  [W-1:0][IDX_W-1:0] tag_a;
  logic                   accept;

  // lane descriptors and per-lane fusion decisions
  generate
    for (genvar i = 0; i < G; i++) begin : g_lane
      assign in_insn[i] = '{has_load: in_has_load[i], has_alu: in_has_alu[i],
                            index: in_index[i], rip: in_rip[i], imm: in_imm[i],
                            rmw: in_rmw[i], brf: in_brf[i]};
      mf_classify i_cls (
        .has_load (grp_q[i].has_load),
        .has_alu  (grp_q[i].has_alu),
        .index    (grp_q[i].index),
        .rip      (grp_q[i].rip),
        .imm      (grp_q[i].imm),
        .rmw      (grp_q[i].rmw),
        .cls      (cls[i])
      );
      assign two[i] = cls[i].two;
      assign brf[i] = grp_q[i].brf;
    end
  endgenerate

  mf_packer #(.G(G), .W(W), .CW(CW)) i_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_q),
    .two       (two),
    .issue     (issue),
    .off       (off),
    .fused_cnt (out_fused_cnt)
  );

  mf_emitter #(.G(G), .W(W), .IDX_W(IDX_W), .CW(CW), .UW(UW), .NW(NW)) i_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .cls         (cls),
    .brf         (brf),
    .issue       (issue),
    .off         (off),
    .seq         (seq_q),
    .vld         (out_slot_vld),
    .kind        (kind_a),
    .tag         (tag_a),
    .eoi         (out_slot_eoi),
    .split       (out_slot_split),
    .br          (out_slot_br),
    .unfused_cnt (out_unfused_cnt),
    .n_issued    (n_issued)
  );

  assign out_slot_kind = kind_a;
  assign out_slot_tag  = tag_a;

  // next state
  always_comb begin
    pend_after = pend_q & ~issue;
    in_ready   = (pend_after == '0);
    accept     = in_ready && (in_valid != '0);
    pend_n     = accept ? in_valid : pend_after;
    grp_n      = accept ? in_insn  : grp_q;
    seq_n      = seq_q + IDX_W'(n_issued);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      seq_q  <= '0;
      grp_q  <= '0;
    end else begin
      pend_q <= pend_n;
      seq_q  <= seq_n;
      if (accept) begin
        grp_q <= grp_n;
      end
    end
  end

  // R10: the held group is frozen while new input is refused
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(grp_q));

  // R11: fused count matches the emitted slots
  a_r11_fused_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    32'(out_fused_cnt) == $countones(out_slot_vld));

  // R12: nothing leaves without a pending lane
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (out_slot_vld == '0 && out_unfused_cnt == '0));

endmodule

// File: tb/test_mf_fuse_select.sv
`timescale 1ns/1ps
module test_mf_fuse_select;

  logic        clk, rst_n;
  logic [3:0]  in_valid, in_has_load, in_has_alu, in_index, in_rip, in_imm, in_rmw, in_brf;
  logic        in_ready;
  logic [3:0]  out_slot_vld, out_slot_eoi, out_slot_split, out_slot_br;
  logic [7:0]  out_slot_kind;
  logic [15:0] out_slot_tag;
  logic [2:0]  out_fused_cnt;
  logic [3:0]  out_unfused_cnt;

  mf_fuse_select i_mf_fuse_select (.*);

  typedef struct {
    int    kind;
    int    tag;
    int    eoi;
    int    split;
    int    br;
    string req;
  } exp_uop_t;

  typedef struct {
    int nslots;
    int unf;
  } exp_cyc_t;

  exp_uop_t uop_q[$];
  exp_cyc_t cyc_q[$];
  int       nchecks = 0;
  int       nerr    = 0;
  int       seq     = 0;
  bit       fin     = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
  endtask

  // driver: waits for ready, drives a group and predicts its output
  task automatic submit(input logic [3:0] v, ld, al, ix, rp, im, rw, bf);
    int cum, unf;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = v; in_has_load = ld; in_has_alu = al; in_index = ix;
    in_rip = rp; in_imm = im; in_rmw = rw; in_brf = bf;
    cum = 0; unf = 0;
    for (int i = 0; i < 4; i++) begin
      if (v[i]) begin
        int    s, u;
        string rq;
        exp_uop_t a, b;
        if (!ld[i])                 begin s = 1; u = 1; rq = "R6"; a.kind = 0; a.split = 0; a.br = bf[i]; end
        else if (!al[i])            begin s = 1; u = 1; rq = "R6"; a.kind = 1; a.split = 0; a.br = 0; end
        else if (rp[i] && im[i])    begin s = 2; u = 2; rq = "R3"; a.split = 0; end
        else if (ix[i] && !rw[i])   begin s = 2; u = 2; rq = "R4"; a.split = 1; end
        else if (ix[i])             begin s = 1; u = 2; rq = "R5"; a.kind = 2; a.split = 0; a.br = bf[i]; end
        else                        begin s = 1; u = 2; rq = "R2"; a.kind = 2; a.split = 0; a.br = bf[i]; end
        if (cum + s > 4) begin
          cyc_q.push_back('{nslots: cum, unf: unf});
          cum = 0; unf = 0;
        end
        cum += s; unf += u;
        a.tag = seq; a.req = rq;
        if (s == 2) begin
          a.kind = 1; a.eoi = 0; a.br = 0;
          b = a; b.kind = 0; b.eoi = 1; b.br = bf[i];
          uop_q.push_back(a);
          uop_q.push_back(b);
        end else begin
          a.eoi = 1;
          uop_q.push_back(a);
        end
        seq = (seq + 1) % 16;
      end
    end
    if (cum > 0) cyc_q.push_back('{nslots: cum, unf: unf});
    @(negedge clk);
    in_valid = '0;
  endtask

  // monitor: pops predictions as slots appear
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      int n;
      n = $countones(out_slot_vld);
      if (n > 0) begin
        if (cyc_q.size() == 0) begin
          chk(0, "R10", "unexpected slots", n, 0);
        end else begin
          exp_cyc_t c;
          c = cyc_q.pop_front();
          chk(n == c.nslots, "R7", "slots this cycle", n, c.nslots);
          chk(int'(out_fused_cnt) == c.nslots, "R11", "fused count", int'(out_fused_cnt), c.nslots);
          chk(int'(out_unfused_cnt) == c.unf, "R11", "unfused count", int'(out_unfused_cnt), c.unf);
        end
        for (int s = 0; s < 4; s++) begin
          if (out_slot_vld[s]) begin
            if (uop_q.size() == 0) begin
              chk(0, "R12", "extra slot", s, -1);
            end else begin
              exp_uop_t e;
              e = uop_q.pop_front();
              chk(int'(out_slot_kind[2*s +: 2]) == e.kind, e.req, "kind", int'(out_slot_kind[2*s +: 2]), e.kind);
              chk(int'(out_slot_split[s]) == e.split, e.req, "split", int'(out_slot_split[s]), e.split);
              chk(int'(out_slot_tag[4*s +: 4]) == e.tag, "R8", "tag", int'(out_slot_tag[4*s +: 4]), e.tag);
              chk(int'(out_slot_eoi[s]) == e.eoi, "R8", "eoi", int'(out_slot_eoi[s]), e.eoi);
              chk(int'(out_slot_br[s]) == e.br, "R9", "branch flag", int'(out_slot_br[s]), e.br);
            end
          end
        end
      end else begin
        chk(out_fused_cnt == 0 && out_unfused_cnt == 0, "R11", "idle counts",
            int'(out_unfused_cnt), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    in_valid = '0; in_has_load = '0; in_has_alu = '0; in_index = '0;
    in_rip = '0; in_imm = '0; in_rmw = '0; in_brf = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "ready", int'(in_ready), 1);
    chk(out_slot_vld == '0, "R1", "slot valid", int'(out_slot_vld), 0);
    chk(out_fused_cnt == 0 && out_unfused_cnt == 0, "R1", "counts", int'(out_unfused_cnt), 0);

    // R2 cmp base-only+imm, R3 rip+imm, R4 indexed, R5 indexed rmw
    submit(4'hF, 4'hF, 4'hF, 4'b1100, 4'b0010, 4'b0011, 4'b1000, 4'b0001);
    // R6 plain ALU with branch, load only, R2 rip without imm, R5 rmw
    submit(4'hF, 4'b1110, 4'b1101, 4'b1000, 4'b0100, 4'b0000, 4'b1000, 4'b1101);
    // R12 holes in the lane mask
    submit(4'b0101, 4'hF, 4'hF, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    // R9 macro and micro fusion together, fused and unlaminated
    submit(4'b0011, 4'b0011, 4'b0011, 4'b0010, 4'b0000, 4'b0001, 4'b0000, 4'b0011);
    // R10 four unlaminated instructions need two cycles; input refused mid-way
    submit(4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
    chk(in_ready == 1'b0, "R10", "ready during first cycle", int'(in_ready), 0);
    in_valid = 4'hF; in_has_load = 4'hF; in_has_alu = 4'hF; in_index = 4'h0;
    in_rip = 4'h0; in_imm = 4'h0; in_rmw = 4'h0; in_brf = 4'hF;
    @(negedge clk);
    in_valid = '0;
    chk(in_ready == 1'b1, "R10", "ready during last cycle", int'(in_ready), 1);
    // R7 and R8 over random groups (tags wrap)
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      submit(r1[3:0] | 4'b0001, r1[7:4] | r1[3:0], r1[11:8] | r2[3:0], r1[15:12],
             r1[19:16], r1[23:20], r1[27:24], r2[7:4]);
    end
    repeat (6) @(negedge clk);
    chk(uop_q.size() == 0, "R7", "pending slots", uop_q.size(), 0);
    chk(cyc_q.size() == 0, "R7", "pending cycles", cyc_q.size(), 0);
    fin = 1;
    summary();
    $finish;
  end

endmodule